// File: doc/BRIEF.md
# Interconnect Performance Monitor Counter Unit

This block is the performance monitor for one clock domain of an on-chip interconnect. Eight 32-bit event counters and one 64-bit cycle counter are controlled through a simple 32-bit register port. Each event counter has a selector that names one source node by a type and an ID. Each node carries a tag input and a bundle of pulse lines, one line per counter. A counter advances on a cycle when a node whose tag equals that counter's selector pulses the line for that counter.

Enables, interrupt enables and overflow flags are kept as 32-bit bitmaps. Bit n belongs to event counter n and bit 31 belongs to the cycle counter. Each bitmap is changed through a pair of addresses: one sets bits where a 1 is written, the other clears them. A global control word starts counting and can zero either group of counters. A level interrupt output is high while any overflow flag is pending on a counter whose interrupt is enabled.

Reads return data in the same cycle the address is presented. Writes take effect on the next rising clock edge.

Top module: `icn_perf_mon`

## Requirements
- R1: Event counter n (0..7) is read and written at byte offset 0x008 + 8*n. A write loads the full 32-bit value and takes priority over any increment in that cycle.
- R2: The selector for counter n is at 0x400 + 4*n and keeps bits 12:0; the other bits read as zero. Bits 12:9 are a node type and bits 8:0 a node ID. Node k's tag is {type, id}. Counter n increments by one on each cycle in which at least one node whose tag equals the selector asserts pulse line k*8+n.
- R3: A counter advances only while the global enable (bit 0 of the control word) and its own enable bit are both 1. The cycle counter advances by one on every such clock.
- R4: The enable bitmap is set by writing ones to 0xC00 and cleared by writing ones to 0xC20. Both addresses read the bitmap. Only bits 0..7 and bit 31 can ever be 1.
- R5: The interrupt-enable bitmap is set through 0xC40 and cleared through 0xC60. Both addresses read it back, and the same bit layout as R4 applies.
- R6: A counter that increments from all ones to zero sets its overflow flag. Writing ones to 0xC80 clears flags and writing ones to 0xCC0 sets them. Both addresses read the pending flags. A wrap in the same cycle as a clear leaves the flag set.
- R7: The interrupt output equals the OR over all bits of (overflow flags AND interrupt enables). It changes in the cycle after the state that causes it.
- R8: The cycle counter's low word is at 0x0F8 and its high word at 0x0FC. Reads show the live value with no latching. A write to one half leaves the other half unchanged and suppresses the increment in that cycle.
- R9: The control word is at 0xE04. Bit 0 is read back. Writing 1 to bit 1 zeroes all event counters and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 read as zero.
- R10: 0xE00 is read-only and returns 0x00000108: the number of event counters in bits 7:0 and a 1 in bit 8 for the cycle counter.
- R11: Every other offset reads as zero. Writes to such offsets change no state.
- R12: After reset all counters, selectors, bitmaps and the control word read zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| node_tag | input | 52 | Per-node {type, id} tags, 13 bits per node |
| node_evt | input | 32 | Event pulses; line k*8+n is node k toward counter n |
| irq | output | 1 | Level interrupt on an enabled pending overflow |

## Verification
A wrong enable, selector or counter value shows up on the next read of that counter as a count off by the number of cycles it was wrongly gated. A wrong wrap shows one cycle later as a missing or extra overflow flag and a wrong interrupt level. The bench reads one register and samples the interrupt output on every cycle and compares both against a reference model. Under dense random traffic, a corrupted state therefore usually shows within a few tens of cycles. Directed sequences wrap both counter kinds on purpose to cover the carry and flag paths.

// File: rtl/icn_perf_mon.sv
module icn_perf_mon #(
  parameter int NUM_EVT   = 8,
  parameter int NUM_NODES = 4,
  parameter int TYPE_W    = 4,
  parameter int ID_W      = 9,
  parameter int AW        = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_we,
  input  logic [AW-1:0]                         reg_addr,
  input  logic [31:0]                           reg_wdata,
  output logic [31:0]                           reg_rdata,
  input  logic [NUM_NODES*(TYPE_W+ID_W)-1:0]    node_tag,
  input  logic [NUM_NODES*NUM_EVT-1:0]          node_evt,
  output logic                                  irq
);
  localparam int TW = TYPE_W + ID_W;
  localparam logic [31:0] MAP = ((32'd1 << NUM_EVT) - 32'd1) | 32'h8000_0000;
  localparam logic [31:0] CFG_VAL = {16'd0, 8'd1, 8'(NUM_EVT)};
  localparam logic [AW-1:0] A_CCL  = AW'(12'h0F8);
  localparam logic [AW-1:0] A_CCH  = AW'(12'h0FC);
  localparam logic [AW-1:0] A_ENS  = AW'(12'hC00);
  localparam logic [AW-1:0] A_ENC  = AW'(12'hC20);
  localparam logic [AW-1:0] A_IES  = AW'(12'hC40);
  localparam logic [AW-1:0] A_IEC  = AW'(12'hC60);
  localparam logic [AW-1:0] A_OVC  = AW'(12'hC80);
  localparam logic [AW-1:0] A_OVS  = AW'(12'hCC0);
  localparam logic [AW-1:0] A_CFG  = AW'(12'hE00);
  localparam logic [AW-1:0] A_CTL  = AW'(12'hE04);

  logic                    gen;
  logic [31:0]             cen, ien, ovs;
  logic [63:0]             cc;
  logic [NUM_EVT*32-1:0]   evc_f;
  logic [NUM_EVT*TW-1:0]   typ_f;
  logic [NUM_EVT-1:0]      ovf_ev;
  logic                    ovf_cc;

  wire        wr_ctl  = reg_we && reg_addr == A_CTL;
  wire        clr_evc = wr_ctl && reg_wdata[1];
  wire        clr_cc  = wr_ctl && reg_wdata[2];
  wire        wr_ccl  = reg_we && reg_addr == A_CCL;
  wire        wr_cch  = reg_we && reg_addr == A_CCH;
  wire        inc_cc  = gen && cen[31];
  wire [31:0] wm      = reg_wdata & MAP;

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_cnt
    localparam logic [AW-1:0] A_C = AW'(8 + 8 * n);
    localparam logic [AW-1:0] A_T = AW'(12'h400 + 4 * n);
    logic [31:0]   cnt;
    logic [TW-1:0] sel;
    logic          hit;

    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_NODES; k++)
        if (node_evt[k*NUM_EVT+n] && node_tag[k*TW +: TW] == sel) hit = 1'b1;
    end

    wire inc  = gen && cen[n] && hit;
    wire wr_c = reg_we && reg_addr == A_C;
    wire wr_t = reg_we && reg_addr == A_T;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        sel <= '0;
      end else begin
        if (wr_t) sel <= reg_wdata[TW-1:0];
        if (wr_c) cnt <= reg_wdata;
        else if (clr_evc) cnt <= '0;
        else if (inc) cnt <= cnt + 32'd1;
      end
    end

    assign ovf_ev[n] = inc && !wr_c && !clr_evc && (&cnt);
    assign evc_f[n*32 +: 32] = cnt;
    assign typ_f[n*TW +: TW] = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc <= '0;
    else if (wr_ccl) cc[31:0] <= reg_wdata;
    else if (wr_cch) cc[63:32] <= reg_wdata;
    else if (clr_cc) cc <= '0;
    else if (inc_cc) cc <= cc + 64'd1;
  end

  assign ovf_cc = inc_cc && !wr_ccl && !wr_cch && !clr_cc && (&cc);

  wire [31:0] hw_ovf = 32'(ovf_ev) | {ovf_cc, 31'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen <= 1'b0;
      cen <= '0;
      ien <= '0;
      ovs <= '0;
    end else begin
      if (wr_ctl) gen <= reg_wdata[0];
      if (reg_we && reg_addr == A_ENS) cen <= cen | wm;
      if (reg_we && reg_addr == A_ENC) cen <= cen & ~wm;
      if (reg_we && reg_addr == A_IES) ien <= ien | wm;
      if (reg_we && reg_addr == A_IEC) ien <= ien & ~wm;
      ovs <= (ovs & ~((reg_we && reg_addr == A_OVC) ? wm : 32'd0))
           | ((reg_we && reg_addr == A_OVS) ? wm : 32'd0)
           | hw_ovf;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CCL:        reg_rdata = cc[31:0];
      A_CCH:        reg_rdata = cc[63:32];
      A_ENS, A_ENC: reg_rdata = cen;
      A_IES, A_IEC: reg_rdata = ien;
      A_OVC, A_OVS: reg_rdata = ovs;
      A_CFG:        reg_rdata = CFG_VAL;
      A_CTL:        reg_rdata = {31'd0, gen};
      default:      reg_rdata = '0;
    endcase
    for (int n = 0; n < NUM_EVT; n++) begin
      if (reg_addr == AW'(8 + 8 * n)) reg_rdata = evc_f[n*32 +: 32];
      if (reg_addr == AW'(12'h400 + 4 * n)) reg_rdata = 32'(typ_f[n*TW +: TW]);
    end
  end

  assign irq = |(ovs & ien);
endmodule

// File: rtl/icn_perf_mon_chk.sv
module icn_perf_mon_chk #(
  parameter int NUM_EVT = 8,
  parameter int AW      = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          irq,
  input logic          gen,
  input logic [31:0]   cen,
  input logic [31:0]   ovs,
  input logic [63:0]   cc
);
  localparam logic [31:0] MAP = ((32'd1 << NUM_EVT) - 32'd1) | 32'h8000_0000;

  p_cc_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !reg_we) |=> $stable(cc));

  p_map_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cen & ~MAP) == 32'd0);

  p_ovs_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> (($past(ovs) & ~ovs) == 32'd0));

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_we));

  p_cc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(12'hE04) && reg_wdata[2]) |=> (cc == 64'd0));

  p_cfg_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(12'hE00)) |-> (reg_rdata != 32'd0));

  p_hole_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(12'h004) || reg_addr == AW'(12'h800)) |-> (reg_rdata == 32'd0));
endmodule

bind icn_perf_mon icn_perf_mon_chk #(.NUM_EVT(NUM_EVT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .gen(gen), .cen(cen), .ovs(ovs), .cc(cc)
);

// File: tb/sim_icn_perf_mon.sv
`timescale 1ns/1ps
module sim_icn_perf_mon;
  localparam int NE = 8, NN = 4, TW = 13;
  localparam logic [31:0] MAP = 32'h8000_00FF;

  logic clk = 0, rst_n = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NN*TW-1:0] tags;
  logic [NN*NE-1:0] evt = '0;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  icn_perf_mon u0 (.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .node_tag(tags), .node_evt(evt), .irq(irq));

  logic [31:0] m_evc [NE];
  logic [12:0] m_typ [NE];
  logic [63:0] m_cc;
  logic [31:0] m_cen, m_ien, m_ovs;
  logic        m_gen;

  function automatic logic [12:0] tag_of(int k);
    return {4'(4 + k), 9'(16 * k + 3)};
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] r = '0;
    for (int n = 0; n < NE; n++) begin
      if (a == 12'(8 + 8 * n)) r = m_evc[n];
      if (a == 12'(12'h400 + 4 * n)) r = 32'(m_typ[n]);
    end
    case (a)
      12'h0F8: r = m_cc[31:0];
      12'h0FC: r = m_cc[63:32];
      12'hC00, 12'hC20: r = m_cen;
      12'hC40, 12'hC60: r = m_ien;
      12'hC80, 12'hCC0: r = m_ovs;
      12'hE00: r = 32'h0000_0108;
      12'hE04: r = {31'd0, m_gen};
      default: ;
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [11:0] a);
    if (a >= 12'h008 && a < 12'h048 && a[2:0] == 3'd0) return "R1";
    if (a >= 12'h400 && a < 12'h420 && a[1:0] == 2'd0) return "R2";
    case (a)
      12'h0F8, 12'h0FC: return "R8";
      12'hC00, 12'hC20: return "R4";
      12'hC40, 12'hC60: return "R5";
      12'hC80, 12'hCC0: return "R6";
      12'hE00: return "R10";
      12'hE04: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < NE; n++) begin m_evc[n] = '0; m_typ[n] = '0; end
    m_cc = '0; m_cen = '0; m_ien = '0; m_ovs = '0; m_gen = 0;
  endtask

  task automatic cyc(logic w, logic [11:0] a, logic [31:0] d, logic [NN*NE-1:0] e);
    logic [31:0] n_evc [NE];
    logic [12:0] n_typ [NE];
    logic [63:0] n_cc;
    logic [31:0] n_cen, n_ien, n_ovs, hw, wm;
    logic        n_gen, ccl, cch, cinc;
    we = w; addr = a; wdata = d; evt = e;
    #1;
    chk(req_of(a), 64'(rdata), 64'(model_read(a)));
    chk("R7", 64'(irq), 64'(|(m_ovs & m_ien)));
    wm = d & MAP; hw = '0;
    for (int n = 0; n < NE; n++) begin
      logic hit = 0;
      for (int k = 0; k < NN; k++) if (e[k*NE+n] && tag_of(k) == m_typ[n]) hit = 1;
      n_typ[n] = (w && a == 12'(12'h400 + 4 * n)) ? d[12:0] : m_typ[n];
      n_evc[n] = m_evc[n];
      if (w && a == 12'(8 + 8 * n)) n_evc[n] = d;
      else if (w && a == 12'hE04 && d[1]) n_evc[n] = '0;
      else if (m_gen && m_cen[n] && hit) begin
        if (m_evc[n] == 32'hFFFF_FFFF) hw[n] = 1;
        n_evc[n] = m_evc[n] + 1;
      end
    end
    ccl = w && a == 12'h0F8; cch = w && a == 12'h0FC; cinc = m_gen && m_cen[31];
    n_cc = m_cc;
    if (ccl) n_cc[31:0] = d;
    else if (cch) n_cc[63:32] = d;
    else if (w && a == 12'hE04 && d[2]) n_cc = '0;
    else if (cinc) begin
      if (m_cc == '1) hw[31] = 1;
      n_cc = m_cc + 1;
    end
    n_gen = (w && a == 12'hE04) ? d[0] : m_gen;
    n_cen = m_cen; n_ien = m_ien;
    if (w && a == 12'hC00) n_cen = m_cen | wm;
    if (w && a == 12'hC20) n_cen = m_cen & ~wm;
    if (w && a == 12'hC40) n_ien = m_ien | wm;
    if (w && a == 12'hC60) n_ien = m_ien & ~wm;
    n_ovs = (m_ovs & ~((w && a == 12'hC80) ? wm : 32'd0))
          | ((w && a == 12'hCC0) ? wm : 32'd0) | hw;
    @(posedge clk);
    for (int n = 0; n < NE; n++) begin m_evc[n] = n_evc[n]; m_typ[n] = n_typ[n]; end
    m_cc = n_cc; m_gen = n_gen; m_cen = n_cen; m_ien = n_ien; m_ovs = n_ovs;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a); cyc(0, a, '0, '0); endtask
  task automatic wr(logic [11:0] a, logic [31:0] d); cyc(1, a, d, '0); endtask

  function automatic logic [11:0] pick_addr(int unsigned r);
    case (r % 11)
      0, 1: return 12'(8 + 8 * ((r >> 4) % NE));
      2:    return 12'(12'h400 + 4 * ((r >> 4) % NE));
      3:    return ((r >> 4) & 1) ? 12'h0FC : 12'h0F8;
      4:    return ((r >> 4) & 1) ? 12'hC20 : 12'hC00;
      5:    return ((r >> 4) & 1) ? 12'hC60 : 12'hC40;
      6:    return ((r >> 4) & 1) ? 12'hCC0 : 12'hC80;
      7:    return ((r >> 4) & 1) ? 12'hE04 : 12'hE00;
      8:    return 12'h800 + 12'(4 * ((r >> 4) % 64));
      9:    return 12'h004;
      default: return 12'h0F8;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int k = 0; k < NN; k++) tags[k*TW +: TW] = tag_of(k);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", 64'(irq), 64'd0);
    addr = 12'hC00; #1 chk("R12", 64'(rdata), 64'd0);
    addr = 12'h008; #1 chk("R12", 64'(rdata), 64'd0);
    rd(12'hE04); rd(12'hC80); rd(12'h0FC); rd(12'h400);
    rd(12'hE00);
    // R2, R3: counter 0 follows node 1 only
    wr(12'h400, 32'(tag_of(1)) | 32'hFFFF_E000);
    rd(12'h400);
    wr(12'h008, 32'hFFFF_FFFE);
    wr(12'hC00, 32'h0000_0001);
    cyc(0, 12'h008, '0, 32'h0000_0002);
    chk("R3", 64'(rdata), 64'(32'hFFFF_FFFE));
    wr(12'hE04, 32'h1);
    cyc(0, 12'h008, '0, 32'h0000_0001);
    cyc(0, 12'h008, '0, 32'h0000_0100);
    chk("R2", 64'(rdata), 64'(32'hFFFF_FFFF));
    cyc(0, 12'h008, '0, 32'h0000_0101);
    rd(12'h008);
    chk("R6", 64'(rdata), 64'd0);
    rd(12'hC80);
    chk("R6", 64'(rdata), 64'd1);
    wr(12'hC40, 32'hFFFF_FFFF);
    rd(12'hC40);
    chk("R5", 64'(rdata), 64'(MAP));
    chk("R7", 64'(irq), 64'd1);
    wr(12'hC80, 32'h1);
    chk("R7", 64'(irq), 64'd0);
    wr(12'hC60, 32'hFFFF_FFFF);
    // R8 cycle counter carry across halves
    wr(12'hE04, 32'h0);
    wr(12'h0F8, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'h5);
    wr(12'hC00, 32'h8000_0000);
    wr(12'hE04, 32'h1);
    wr(12'hE04, 32'h0);
    rd(12'h0FC);
    chk("R8", 64'(rdata), 64'd6);
    rd(12'h0F8);
    chk("R8", 64'(rdata), 64'd0);
    // R9 clear bits
    wr(12'hE04, 32'h6);
    rd(12'h0FC); chk("R9", 64'(rdata), 64'd0);
    rd(12'hE04); chk("R9", 64'(rdata), 64'd0);
    // R11 writes to holes change nothing
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h004); chk("R11", 64'(rdata), 64'd0);
    rd(12'hC00); chk("R4", 64'(rdata), 64'(32'h8000_0001));
    wr(12'hC20, 32'h8000_0000);
    wr(12'hE04, 32'h1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int unsigned r = $urandom;
      logic w = ($urandom % 10) < 3;
      logic [11:0] a = pick_addr(r);
      logic [31:0] d = $urandom;
      logic [NN*NE-1:0] e = $urandom & $urandom;
      if (w && a < 12'h048 && (r & 32'h100) != 0) d = 32'hFFFF_FFF0 | (d & 32'hF);
      if (w && a >= 12'h400 && a < 12'h420 && ($urandom % 10) < 7) d = 32'(tag_of($urandom % NN));
      if (w && a == 12'hE04) d = {29'd0, ($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 10) != 0};
      if (w && a == 12'h0FC && (r & 32'h100) != 0) d = 32'hFFFF_FFFF;
      if (w && a == 12'h0F8 && (r & 32'h100) != 0) d = 32'hFFFF_FFF0;
      cyc(w, a, d, e);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule